// File: doc/BRIEF.md
# Strided Vector Memory Address Generator

This block turns one vector memory instruction into a stream of per-element word requests. A start pulse captures a base word address, a stride counted in 64-bit words, a vector length and a load/store flag. The block then presents element i at address base + i × stride, one element per cycle at most. Each address is split into a bank number and an address inside that bank, because memory is interleaved across sixteen banks.

A bank needs four processor cycles to recover after an access. The block keeps a busy timer for each bank and does not present a request to a bank that is still recovering. The sustained rate therefore depends on the stride. Unit stride runs at one element per cycle. A stride of 16 hits one bank every time and runs at one element every four cycles. The bank array answers each presented request with a grant. A request that is not granted is held unchanged.

The controller has three states. ST_IDLE waits for a start. ST_RUN presents and issues elements. ST_FIN raises the done pulse for one cycle. The named transitions are:
- go_run: ST_IDLE to ST_RUN, on a start with a nonzero length.
- go_empty: ST_IDLE to ST_FIN, on a start with zero length.
- go_last: ST_RUN to ST_FIN, when the final element is granted.
- go_rest: ST_FIN to ST_IDLE, unconditionally.

Top module: `svag_top`

## Requirements
- R1: Right after reset, req_valid and done are both low.
- R2: Element i is presented at word address A = (base + i × stride) mod 2^32. req_bank carries A[3:0] and req_word carries A[31:4].
- R3: req_elem equals the element number i, starting at 0 and rising by one after each grant. While a presented request is not granted, its bank, word and element values stay unchanged.
- R4: An element is issued only in a cycle where req_valid and grant are both high. At most one element is issued per cycle, and req_valid is never high while done is high.
- R5: After an issue to bank b, no request to b is presented during the next three cycles. A request whose bank is free is presented without extra delay.
- R6: The number of issued elements equals the captured vector length. A length above 64 is treated as 64.
- R7: done is high for exactly one cycle, and that cycle directly follows the cycle in which the last element was granted.
- R8: A start with vector length 0 issues no request and raises done in the cycle after the start.
- R9: A start pulse arriving while the block is in ST_RUN or ST_FIN is ignored. The running sequence keeps its captured parameters.
- R10: req_store equals the load/store flag captured at the start (1 = store) for every element of that vector.
- R11: After an accepted start with a nonzero length, element 0 is presented in the next cycle if its bank is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a vector access |
| base | input | 32 | Word address of element 0 |
| stride | input | 32 | Distance between elements in words, two's complement |
| vlen | input | 7 | Vector length; values above 64 act as 64 |
| is_store | input | 1 | 1 for a store, 0 for a load |
| grant | input | 1 | Bank array accepts the presented request this cycle |
| req_valid | output | 1 | A request is presented |
| req_bank | output | 4 | Bank number of the request |
| req_word | output | 28 | Word address inside the bank |
| req_elem | output | 6 | Element number of the request |
| req_store | output | 1 | Captured load/store flag |
| done | output | 1 | One-cycle pulse after the last issue |

## Verification
The hardest case to reach is a bank that is still recovering while the next element already targets it. Reaching it also requires the busy window to overlap a withheld grant or the first elements of the next vector. Strides of 0, 8, 16 and 32 are mixed with grants drawn at random rates, so stalls caused by recovery and stalls caused by grant interleave. Back-to-back vectors then start against banks whose timers are still running. A spurious start is also injected in mid-run and during the done cycle.

// File: rtl/svag_pkg.sv
package svag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } svag_state_e;
endpackage

// File: rtl/svag_bank_timers.sv
// Per-bank recovery counters: a bank is busy while its counter is nonzero.
module svag_bank_timers #(
    parameter int NBANK    = 16,
    parameter int BUSY_CYC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      issue,
    input  logic [$clog2(NBANK)-1:0]  issue_bank,
    output logic [NBANK-1:0]          bank_busy
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int CNT_W  = $clog2(BUSY_CYC + 1);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (issue && (issue_bank == BANK_W'(g))) begin
                cnt_q <= CNT_W'(BUSY_CYC - 1);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end

        assign bank_busy[g] = (cnt_q != '0);
    end
endmodule

// File: rtl/svag_stepper.sv
// Address accumulator and element counter.
module svag_stepper #(
    parameter int ADDR_W = 32,
    parameter int VL_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [VL_W-1:0]   cur_elem
);
    logic [ADDR_W-1:0] stride_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_elem <= '0;
            stride_q <= '0;
        end else if (load) begin
            cur_addr <= base;
            cur_elem <= '0;
            stride_q <= stride;
        end else if (step) begin
            cur_addr <= cur_addr + stride_q;
            cur_elem <= cur_elem + VL_W'(1);
        end
    end
endmodule

// File: rtl/svag_ctrl.sv
// Sequencing state machine.
module svag_ctrl
    import svag_pkg::*;
#(
    parameter int VLEN_MAX = 64,
    parameter int VL_W     = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VL_W-1:0] vlen,
    input  logic            is_store,
    input  logic            grant,
    input  logic            bank_free,
    input  logic [VL_W-1:0] cur_elem,
    output logic            load,
    output logic            step,
    output logic            req_valid,
    output logic            done,
    output logic            store_q
);
    svag_state_e     state_q, state_d;
    logic [VL_W-1:0] len_q;
    logic [VL_W-1:0] len_clamped;
    logic            last_elem;

    always_comb begin
        len_clamped = (vlen > VL_W'(VLEN_MAX)) ? VL_W'(VLEN_MAX) : vlen;
    end

    assign last_elem = (cur_elem == (len_q - VL_W'(1)));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured instruction fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            store_q <= 1'b0;
        end else if (load) begin
            len_q   <= len_clamped;
            store_q <= is_store;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (len_clamped == '0) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                if (step && last_elem) begin
                    state_d = ST_FIN;
                end
            end
            ST_FIN: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        load      = 1'b0;
        req_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: load      = start;
            ST_RUN:  req_valid = bank_free;
            ST_FIN:  done      = 1'b1;
            default: ;
        endcase
        step = req_valid && grant;
    end
endmodule

// File: rtl/svag_top.sv
module svag_top #(
    parameter int ADDR_W   = 32,
    parameter int NBANK    = 16,
    parameter int BUSY_CYC = 4,
    parameter int VLEN_MAX = 64,
    localparam int BANK_W  = $clog2(NBANK),
    localparam int WORD_W  = ADDR_W - BANK_W,
    localparam int VL_W    = $clog2(VLEN_MAX + 1),
    localparam int ELEM_W  = $clog2(VLEN_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [VL_W-1:0]   vlen,
    input  logic              is_store,
    input  logic              grant,
    output logic              req_valid,
    output logic [BANK_W-1:0] req_bank,
    output logic [WORD_W-1:0] req_word,
    output logic [ELEM_W-1:0] req_elem,
    output logic              req_store,
    output logic              done
);
    logic [ADDR_W-1:0] cur_addr;
    logic [VL_W-1:0]   cur_elem;
    logic [NBANK-1:0]  bank_busy;
    logic              load, step, bank_free;

    assign req_bank  = cur_addr[BANK_W-1:0];
    assign req_word  = cur_addr[ADDR_W-1:BANK_W];
    assign req_elem  = cur_elem[ELEM_W-1:0];
    assign bank_free = !bank_busy[req_bank];

    svag_stepper #(.ADDR_W(ADDR_W), .VL_W(VL_W)) u_step (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .base(base), .stride(stride),
        .cur_addr(cur_addr), .cur_elem(cur_elem)
    );

    svag_bank_timers #(.NBANK(NBANK), .BUSY_CYC(BUSY_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .issue(step), .issue_bank(req_bank),
        .bank_busy(bank_busy)
    );

    svag_ctrl #(.VLEN_MAX(VLEN_MAX), .VL_W(VL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
        .is_store(is_store), .grant(grant), .bank_free(bank_free),
        .cur_elem(cur_elem), .load(load), .step(step),
        .req_valid(req_valid), .done(done), .store_q(req_store)
    );
endmodule

// File: rtl/svag_chk.sv
module svag_chk #(
    parameter int BANK_W = 4,
    parameter int WORD_W = 28,
    parameter int ELEM_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant,
    input logic              req_valid,
    input logic [BANK_W-1:0] req_bank,
    input logic [WORD_W-1:0] req_word,
    input logic [ELEM_W-1:0] req_elem,
    input logic              done
);
    // R3
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !grant) |=> (req_valid && $stable(req_bank)
                                   && $stable(req_word) && $stable(req_elem)));

    // R3
    elem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && grant) |=> (!req_valid || (req_elem == $past(req_elem) + ELEM_W'(1))));

    // R5
    bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && grant) |=> !(req_valid && (req_bank == $past(req_bank))));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);
endmodule

bind svag_top svag_chk #(.BANK_W(BANK_W), .WORD_W(WORD_W), .ELEM_W(ELEM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req_valid(req_valid),
    .req_bank(req_bank), .req_word(req_word), .req_elem(req_elem), .done(done)
);

// File: tb/sim_svag_top.sv
module sim_svag_top;
    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base = '0;
    logic [31:0] stride = '0;
    logic [6:0]  vlen = '0;
    logic        is_store = 1'b0;
    logic        grant = 1'b0;
    logic        req_valid;
    logic [3:0]  req_bank;
    logic [27:0] req_word;
    logic [5:0]  req_elem;
    logic        req_store;
    logic        done;

    always #10ns clk = ~clk;

    svag_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
        .vlen(vlen), .is_store(is_store), .grant(grant), .req_valid(req_valid),
        .req_bank(req_bank), .req_word(req_word), .req_elem(req_elem),
        .req_store(req_store), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // reference state
    bit          m_active = 0;
    bit          m_done_next = 0;
    int          m_i = 0;
    int          m_n = 0;
    logic [31:0] m_base = '0;
    logic [31:0] m_stride = '0;
    bit          m_store = 0;
    int          last_issue [16];
    int          dut_issued = 0;

    function automatic logic [31:0] addr_of(logic [31:0] b, logic [31:0] s, int i);
        return b + s * 32'(i);
    endfunction

    function automatic int clampn(int n);
        return (n > 64) ? 64 : n;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // one cycle: compare at negedge, then drive and advance the reference
    task automatic step(bit st, logic [31:0] b, logic [31:0] s, int n, bit str, int gpct);
        logic [31:0] ea;
        bit ev, g, idle;
        ea = addr_of(m_base, m_stride, m_i);
        ev = m_active && ((cyc - last_issue[ea[3:0]]) >= BUSY);
        chk("R5 R11", "req_valid", req_valid, ev);
        chk("R7", "done", done, m_done_next);
        if (ev && req_valid) begin
            chk("R2", "req_bank", req_bank, ea[3:0]);
            chk("R2", "req_word", req_word, ea[31:4]);
            chk("R3", "req_elem", req_elem, m_i);
            chk("R10", "req_store", req_store, m_store);
        end
        g = ($urandom_range(99) < gpct);
        grant = g;
        start = st;
        if (st) begin
            base = b; stride = s; vlen = 7'(n); is_store = str;
        end
        if (req_valid && g) dut_issued++;
        idle = !m_active && !m_done_next;
        m_done_next = 0;
        if (ev && g) begin
            last_issue[ea[3:0]] = cyc;
            m_i++;
            if (m_i == m_n) begin
                m_active = 0;
                m_done_next = 1;
            end
        end
        if (st && idle) begin
            m_n = clampn(n); m_base = b; m_stride = s; m_store = str; m_i = 0;
            if (m_n == 0) m_done_next = 1;
            else m_active = 1;
        end
        @(posedge clk);
        cyc++;
        @(negedge clk);
        start = 0;
    endtask

    // whole vector; poke injects ignored starts in mid-run and during done (R9)
    task automatic run_vec(logic [31:0] b, logic [31:0] s, int n, bit str, int gpct, bit poke);
        int guard;
        dut_issued = 0;
        step(1, b, s, n, str, gpct);
        guard = 0;
        while ((m_active || m_done_next) && guard < 2000) begin
            if (poke && m_active && m_i == 1)
                step(1, b + 32'd7, s + 32'd1, 3, !str, gpct);
            else if (poke && m_done_next)
                step(1, b + 32'd9, s, 5, str, gpct);
            else
                step(0, '0, '0, 0, 0, gpct);
            guard++;
        end
        step(0, '0, '0, 0, 0, gpct);
        chk("R6 R9", "issued count", dut_issued, clampn(n));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 16; k++) last_issue[k] = -100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "req_valid after reset", req_valid, 0);
        chk("R1", "done after reset", done, 0);
        rst_n = 1'b1;

        // R2 R11: unit stride, full grant, one per cycle
        run_vec(32'h0000_1000, 32'd1, 16, 0, 100, 0);
        // R5: same bank each element
        run_vec(32'h0000_2003, 32'd16, 8, 1, 100, 0);
        // R5: two banks alternate
        run_vec(32'h0000_0005, 32'd8, 10, 0, 100, 0);
        // R2: negative stride wraps through zero
        run_vec(32'h0000_0005, 32'hFFFF_FFFF, 20, 1, 100, 0);
        // R8: zero length
        step(1, 32'h40, 32'd1, 0, 0, 100);
        chk("R8", "done after empty start", done, 1);
        chk("R8", "no request on empty start", req_valid, 0);
        step(0, '0, '0, 0, 0, 100);
        // R6: length above 64 clamps
        run_vec(32'h0000_0100, 32'd3, 100, 0, 100, 0);
        // R3: stalls from withheld grant
        run_vec(32'h0000_0300, 32'd1, 24, 1, 40, 0);
        // R9: ignored starts
        run_vec(32'h0000_0500, 32'd2, 12, 0, 70, 1);
        // R5: zero stride, back to back against running timers
        run_vec(32'h0000_0700, 32'd0, 6, 0, 100, 0);
        run_vec(32'h0000_0700, 32'd32, 6, 1, 100, 0);

        for (int v = 0; v < 30; v++) begin
            logic [31:0] rb, rs;
            int sel;
            rb = $urandom;
            sel = $urandom_range(3);
            case (sel)
                0: rs = 32'($urandom_range(40));
                1: rs = 32'(16 * $urandom_range(3));
                2: rs = -32'($urandom_range(20));
                default: rs = $urandom;
            endcase
            run_vec(rb, rs, $urandom_range(0, 80), 1'($urandom_range(1)),
                    $urandom_range(30, 100), 1'($urandom_range(1)));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule